// File: doc/BRIEF.md
# 14-Bit Pulse-Width Modulator with Staged Duty Register

This block drives one digital output with a fixed-period pulse train whose high time is set by a 14-bit duty value. Software programs it over a small 8-bit register bus. The bus has three write-only registers: a control register that holds a one-bit rate select, a low duty byte, and a 6-bit upper duty field. The duty value is written in two steps. The low byte goes in first and is held in a staging register. The write of the upper field then joins both parts and commits the full 14-bit value to the waveform generator in a single step, so the output never sees half of an update.

All timing is counted in ticks of a system clock enable. With the rate select at 0, the period counter moves on every enabled tick. The period is then 16384 ticks and the high time can be set in steps of one tick. With the rate select at 1, the counter moves on every second enabled tick, which doubles both the period and the step size. A committed value is taken up only when a period starts. The period that is running when the write arrives is always finished with its old value.

Top module: `pwm14_top`

## Requirements
- R1: After reset the rate select is 0, the committed duty is 0, and the output stays low for the whole first period, even if a duty value is committed during that period.
- R2: The register map is: address 0 is control (bit 0 is the rate select), address 1 is the upper duty field (wdata bits 5:0 become duty bits 13:8), and address 2 is the low duty byte (duty bits 7:0). A register is written when `wr_en_i` is high on a clock edge.
- R3: A read of address 0, 1 or 2 returns 0xFF, and a read of address 3 returns 0x00. `rdata_o` follows `addr_i` combinationally.
- R4: A write to the low byte alone only updates the staging byte. It never changes the committed duty or the output.
- R5: A write to the upper field commits the value {wdata[5:0], staged low byte} as the new duty.
- R6: A newly committed duty takes effect when the next period starts. The period that is running when the write arrives completes unchanged.
- R7: With the rate select at 0, one period lasts 16384 enabled ticks and the output is high for the first D of them, where D is the committed duty.
- R8: With the rate select at 1, one period lasts 32768 enabled ticks and the output is high for the first 2·D of them.
- R9: A duty of 0 keeps the output low for the whole period. A duty of 16383 makes the output low for exactly one step at the end of each period.
- R10: While `clk_en_i` is low, the period counter, the prescaler phase and the output all hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | System tick enable; timing is counted in enabled ticks |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (0xFF for the three mapped registers) |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench commits a new duty in the middle of a period that is being measured. A design that takes the value up at once would show a shortened or stretched high run in that period. Both boundary duties are covered. For 16383, a comparison that is off by one either hides the single low step at the end of the period or merges two periods into one. For 0, a design that loads the staging byte on its own would go high after a write to the low byte alone. The bench also holds the tick enable low during a high run, where a counter that does not stop would shorten the measured high time. A rate-select measurement shows whether both the period and the step are doubled, rather than only one of them.

// File: rtl/pwm14_pkg.sv
package pwm14_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_HI   = 2'd1,
    REG_LO   = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm14_regs.sv
module pwm14_regs
  import pwm14_pkg::*;
#(
  parameter int DUTY_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_o,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int HI_W = DUTY_W - DATA_W;

  logic              sel_q;
  logic [DATA_W-1:0] lo_q;
  logic [DUTY_W-1:0] duty_q;
  logic              wr_hi;

  assign wr_hi = wr_en_i && (addr_i == REG_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      lo_q   <= '0;
      duty_q <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        REG_CTRL: sel_q  <= wdata_i[0];
        REG_LO:   lo_q   <= wdata_i;
        REG_HI:   duty_q <= {wdata_i[HI_W-1:0], lo_q};
        default:  ;
      endcase
    end
  end

  // write-only registers: mapped addresses read all ones
  always_comb begin
    rdata_o = (addr_i == REG_NONE) ? '0 : '1;
  end

  assign sel_o  = sel_q;
  assign duty_o = duty_q;

  // R4
  duty_only_on_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(duty_q) |-> $past(wr_hi));
endmodule

// File: rtl/pwm14_prescaler.sv
module pwm14_prescaler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_i,
  output logic step_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ph_q <= 1'b0;
    else if (en_i) ph_q <= ~ph_q;
  end

  assign step_o = en_i && (!sel_i || ph_q);

  // R8
  half_rate_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && step_o) |=> !(sel_i && step_o));

  // R10
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(ph_q));
endmodule

// File: rtl/pwm14_core.sv
module pwm14_core #(
  parameter int DUTY_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam logic [DUTY_W-1:0] CNT_MAX = '1;

  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] active_q;
  logic              wrap;

  assign wrap = step_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap) active_q <= duty_i;
    end
  end

  assign pwm_o = (cnt_q < active_q);

  // R6
  load_at_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_q) |-> $past(wrap));

  // R10
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_i) |-> $stable(cnt_q));

  // R9
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q == '0) |-> !pwm_o);
endmodule

// File: rtl/pwm14_top.sv
module pwm14_top
  import pwm14_pkg::*;
#(
  parameter int DUTY_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  logic              sel;
  logic              step;
  logic [DUTY_W-1:0] duty;

  pwm14_regs #(.DUTY_W(DUTY_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .sel_o   (sel),
    .duty_o  (duty)
  );

  pwm14_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .sel_i  (sel),
    .step_o (step)
  );

  pwm14_core #(.DUTY_W(DUTY_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .duty_i (duty),
    .pwm_o  (pwm_o)
  );
endmodule

// File: tb/tb_pwm14_top.sv
module tb_pwm14_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_en_i = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       pwm_o;

  pwm14_top dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clk_en_i (clk_en_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pwm_o    (pwm_o)
  );

  always #5 clk_i = ~clk_i;

  typedef struct {
    int    high;
    int    period;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   checks = 0;
  int   errors = 0;
  int   popped = 0;
  int   done = 0;
  int   hi_cnt = 0;
  int   per_cnt = 0;
  bit   measuring = 1'b0;
  bit   pwm_prev = 1'b0;
  bit   en_at_pos = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(rdata_o == exp, "R3", int'(rdata_o), int'(exp));
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
    end
  endtask

  task automatic push(input int high, input int period, input string tag);
    exp_t e;
    e.high = high;
    e.period = period;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(posedge clk_i) en_at_pos <= clk_en_i;

  // monitor: rise-to-rise measurement in enabled ticks
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      pwm_prev  = 1'b0;
      measuring = 1'b0;
    end else begin
      if (pwm_o && !pwm_prev) begin
        if (measuring) begin
          check(hi_cnt == cur.high, cur.tag, hi_cnt, cur.high);
          check(per_cnt == cur.period, cur.tag, per_cnt, cur.period);
          done++;
          measuring = 1'b0;
        end
        if (exp_q.size() > 0) begin
          cur = exp_q.pop_front();
          measuring = 1'b1;
          hi_cnt = 0;
          per_cnt = 0;
          popped++;
        end
      end
      if (measuring && en_at_pos) begin
        per_cnt++;
        if (pwm_o) hi_cnt++;
      end
      pwm_prev = pwm_o;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int highs;
    repeat (5) @(negedge clk_i);
    #1;
    // R1: output low while held in reset
    check(pwm_o == 1'b0, "R1", int'(pwm_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    rd_check(2'd0, 8'hFF);
    rd_check(2'd1, 8'hFF);
    rd_check(2'd2, 8'hFF);
    rd_check(2'd3, 8'h00);

    // R2 map: ctrl=0, upper=1, low=2; commit 16383 during the first period
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'h3F);
    push(16383, 16384, "R6/R7/R9");
    // R1: first period stays low despite the commit
    count_high(16000, highs);
    check(highs == 0, "R1", highs, 0);

    // commit 0x2A55 mid-period of the 16383 measurement (R6)
    wait (popped == 1);
    wr(2'd2, 8'h55);
    wr(2'd1, 8'h2A);
    push(16'h2A55, 16384, "R2/R5/R7/R10");

    // R10: pause the tick enable inside the 0x2A55 high run
    wait (popped == 2);
    @(negedge clk_i);
    clk_en_i = 1'b0;
    repeat (40) @(negedge clk_i);
    clk_en_i = 1'b1;

    // duty 0, then a low-byte-only write that must not commit (R4, R9)
    wait (done == 2);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    repeat (16384) @(negedge clk_i);
    count_high(20000, highs);
    check(highs == 0, "R4/R9", highs, 0);

    // R8: rate select 1 with duty {0x05, staged 0xFF}
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h05);
    push(2 * 16'h05FF, 32768, "R8");
    wait (done == 3);

    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule